// File: doc/BRIEF.md
# Monitor channel message scheduler

The scheduler sends two-byte messages onto a serial-control monitor channel. A message is either an interrupt indication or a register-read response. An interrupt indication is raised when the receive deframer writes a new validated value into one of three maintenance registers: byte register A, byte register B, or the 12-bit embedded-operations register. A register-read response answers a read command from the host. The deframer writes a register only after its three-times match check has finished, so every update pulse that reaches this block is final.

Each source has one pending flag. A free message slot goes to a pending indication before any read response. Among the indications the embedded-operations register comes first, then byte register A, then byte register B. Sending an indication reads the source register and clears its flag in the same step. The first byte of every message holds a message code, so the far end can tell what kind of message it is. The bytes leave one after the other over a valid/ready handshake.

Top module: `mcs_monitor_sched`

## Requirements
- R1: After reset `tx_valid` is 0, and it stays 0 until something is raised.
- R2: The embedded-operations indication is the byte `{4'h1, e[11:8]}` followed by the byte `e[7:0]`. Here `e` packs the three address bits, the data/message flag and then the eight information bits, with the first address bit in `e[11]` and the last information bit in `e[0]`.
- R3: The indication for byte register A is `8'h20` followed by the value of A. The indication for byte register B is `8'h30` followed by the value of B.
- R4: When several indications are pending they go out in this order: the embedded-operations register, then A, then B.
- R5: A read response is the byte `{4'h8, addr[3:0]}` followed by the data byte that was latched with the command. It starts only when no indication flag is pending.
- R6: If an update and a read command arrive in the same cycle, the indication is sent before the response.
- R7: If a source is updated again while its flag is still pending, it produces only one indication, and that indication carries the latest value.
- R8: Starting an indication clears its flag, so each update is reported once.
- R9: If an update arrives in the same cycle that its source's earlier indication is started, the flag stays set. The old value is sent first and the new value follows in a second indication.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_byte` holds its value. The second byte of a message follows the first with no gap, and a new message starts only after the last byte of the current one has been accepted.
- R11: A read command that arrives while an earlier response is still waiting replaces that response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_eoc | input | 1 | Deframer wrote the embedded-operations register |
| eoc_val | input | 12 | New embedded-operations value |
| upd_a | input | 1 | Deframer wrote byte register A |
| a_val | input | 8 | New value of A |
| upd_b | input | 1 | Deframer wrote byte register B |
| b_val | input | 8 | New value of B |
| rd_cmd | input | 1 | Host read command |
| rd_addr | input | 4 | Address of the register being read |
| rd_data | input | 8 | Data read from that register |
| tx_valid | output | 1 | Channel byte is valid |
| tx_byte | output | 8 | Channel byte |
| tx_ready | input | 1 | Channel accepts the byte |

## Verification
The bench targets these corner cases:
- A read command and an update in the same cycle. A design that got this wrong would answer the host first.
- A second update while the flag is still pending. A design that got this wrong would send two indications, or would send the stale value.
- An update in the exact cycle its earlier indication is granted. A design that got this wrong would lose the new value, because the clear overwrites the set.
- Two read commands queued behind an indication. A design that got this wrong would send the older response.
- Long stalls on `tx_ready`. A design that got this wrong would let the byte change under a stall, leave a gap inside a message, or start the next message early.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int BYTE_W  = 8;
  localparam int EOC_W   = 12;
  localparam int ADDR_W  = 4;
  localparam int NSRC    = 3;
  localparam int SRC_W   = $clog2(NSRC);
  localparam int SRC_EOC = 0;
  localparam int SRC_A   = 1;
  localparam int SRC_B   = 2;

  localparam logic [3:0]        CODE_EOC_NIB = 4'h1;
  localparam logic [BYTE_W-1:0] CODE_A       = 8'h20;
  localparam logic [BYTE_W-1:0] CODE_B       = 8'h30;
  localparam logic [3:0]        CODE_RD_NIB  = 4'h8;

  typedef struct packed {
    logic [BYTE_W-1:0] b0;
    logic [BYTE_W-1:0] b1;
  } msg_t;

  function automatic msg_t ind_msg(input logic [SRC_W-1:0] src,
                                   input logic [EOC_W-1:0] v);
    msg_t m;
    case (src)
      SRC_W'(SRC_EOC): m = '{b0: {CODE_EOC_NIB, v[11:8]}, b1: v[7:0]};
      SRC_W'(SRC_A):   m = '{b0: CODE_A, b1: v[7:0]};
      default:         m = '{b0: CODE_B, b1: v[7:0]};
    endcase
    return m;
  endfunction

  function automatic msg_t rsp_msg(input logic [ADDR_W-1:0] addr,
                                   input logic [BYTE_W-1:0] d);
    msg_t m;
    m.b0 = {CODE_RD_NIB, addr};
    m.b1 = d;
    return m;
  endfunction

  function automatic logic [SRC_W-1:0] oh_index(input logic [NSRC-1:0] oh);
    logic [SRC_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < NSRC; i++)
      if (oh[i]) idx = SRC_W'(i);
    return idx;
  endfunction
endpackage

// File: rtl/mcs_src_bank.sv
module mcs_src_bank #(
  parameter int NSRC  = 3,
  parameter int VAL_W = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NSRC-1:0]             set,
  input  logic [NSRC-1:0][VAL_W-1:0]  val,
  input  logic [NSRC-1:0]             clr,
  output logic [NSRC-1:0]             pend,
  output logic [NSRC-1:0][VAL_W-1:0]  held
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[i] <= 1'b0;
        held[i] <= '0;
      end else if (set[i]) begin
        pend[i] <= 1'b1;
        held[i] <= val[i];
      end else if (clr[i]) begin
        pend[i] <= 1'b0;
      end
    end

    a_r8_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
      clr[i] && !set[i] |=> !pend[i]);
    a_r7_latest_value_kept: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> pend[i] && held[i] == $past(val[i]));
  end
endmodule

// File: rtl/mcs_pick.sv
module mcs_pick #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            free,
  input  logic [NSRC-1:0] pend,
  input  logic            rd_pend,
  output logic [NSRC-1:0] gnt,
  output logic            gnt_rd
);
  always_comb begin
    logic taken;
    taken = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      gnt[i] = free && pend[i] && !taken;
      taken  = taken | pend[i];
    end
    gnt_rd = free && rd_pend && !taken;
  end

  a_r4_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt, gnt_rd}));
  a_r5_read_waits_for_flags: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_rd |-> pend == '0);
  a_r4_eoc_before_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    pend[0] && free |-> gnt[0]);
endmodule

// File: rtl/mcs_ser.sv
module mcs_ser
  import mcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  msg_t              msg,
  output logic              free,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_ready
);
  logic busy, second;
  msg_t cur;
  logic last_acc;

  assign last_acc = busy && second && tx_ready;
  assign free     = !busy || last_acc;
  assign tx_valid = busy;
  assign tx_byte  = second ? cur.b1 : cur.b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      second <= 1'b0;
      cur    <= '0;
    end else if (load) begin
      busy   <= 1'b1;
      second <= 1'b0;
      cur    <= msg;
    end else if (busy && tx_ready) begin
      if (second) busy <= 1'b0;
      second <= !second;
    end
  end

  a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte));
  a_r10_second_follows: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && !second |=> tx_valid);
  a_r10_no_early_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy || (second && tx_ready));
endmodule

// File: rtl/mcs_monitor_sched.sv
module mcs_monitor_sched
  import mcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_eoc,
  input  logic [EOC_W-1:0]  eoc_val,
  input  logic              upd_a,
  input  logic [BYTE_W-1:0] a_val,
  input  logic              upd_b,
  input  logic [BYTE_W-1:0] b_val,
  input  logic              rd_cmd,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_ready
);
  logic [NSRC-1:0]            set_v, pend_v, gnt_v;
  logic [NSRC-1:0][EOC_W-1:0] val_v, held_v;
  logic                       free, gnt_rd, load;
  logic                       rd_pend;
  logic [ADDR_W-1:0]          rd_addr_q;
  logic [BYTE_W-1:0]          rd_data_q;
  logic [SRC_W-1:0]           src_idx;
  msg_t                       next_msg;

  assign set_v[SRC_EOC] = upd_eoc;
  assign set_v[SRC_A]   = upd_a;
  assign set_v[SRC_B]   = upd_b;
  assign val_v[SRC_EOC] = eoc_val;
  assign val_v[SRC_A]   = {{(EOC_W-BYTE_W){1'b0}}, a_val};
  assign val_v[SRC_B]   = {{(EOC_W-BYTE_W){1'b0}}, b_val};

  mcs_src_bank #(.NSRC(NSRC), .VAL_W(EOC_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .set(set_v), .val(val_v),
    .clr(gnt_v), .pend(pend_v), .held(held_v));

  mcs_pick #(.NSRC(NSRC)) u_pick (
    .clk(clk), .rst_n(rst_n), .free(free), .pend(pend_v),
    .rd_pend(rd_pend), .gnt(gnt_v), .gnt_rd(gnt_rd));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend   <= 1'b0;
      rd_addr_q <= '0;
      rd_data_q <= '0;
    end else if (rd_cmd) begin
      rd_pend   <= 1'b1;
      rd_addr_q <= rd_addr;
      rd_data_q <= rd_data;
    end else if (gnt_rd) begin
      rd_pend   <= 1'b0;
    end
  end

  assign src_idx  = oh_index(gnt_v);
  assign load     = gnt_rd || (gnt_v != '0);
  assign next_msg = gnt_rd ? rsp_msg(rd_addr_q, rd_data_q)
                           : ind_msg(src_idx, held_v[src_idx]);

  mcs_ser u_ser (
    .clk(clk), .rst_n(rst_n), .load(load), .msg(next_msg), .free(free),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready));

  a_r11_newest_read_kept: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd |=> rd_pend && rd_data_q == $past(rd_data));
  a_r6_read_not_before_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd && (set_v != '0) |=> !gnt_rd);
endmodule

// File: tb/sim_mcs_monitor_sched.sv
module sim_mcs_monitor_sched;
  logic clk = 1'b0, rst_n = 1'b0;
  logic upd_eoc = 0, upd_a = 0, upd_b = 0, rd_cmd = 0, tx_ready = 0;
  logic [11:0] eoc_val = '0;
  logic [7:0]  a_val = '0, b_val = '0, rd_data = '0;
  logic [3:0]  rd_addr = '0;
  logic        tx_valid;
  logic [7:0]  tx_byte;

  int tests = 0, fails = 0;
  bit done = 0;
  byte unsigned got[$], expq[$], mq[$];
  bit m_pe, m_pa, m_pb, m_pr;
  logic [11:0] m_ve;
  logic [7:0]  m_va, m_vb, m_rd;
  logic [3:0]  m_ra;

  always #10 clk = ~clk;

  mcs_monitor_sched u0 (.clk(clk), .rst_n(rst_n), .upd_eoc(upd_eoc), .eoc_val(eoc_val),
    .upd_a(upd_a), .a_val(a_val), .upd_b(upd_b), .b_val(b_val), .rd_cmd(rd_cmd),
    .rd_addr(rd_addr), .rd_data(rd_data), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .tx_ready(tx_ready));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model of the message stream, written as queues
  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      {m_pe, m_pa, m_pb, m_pr} = '0;
    end else begin
      bit acc, fr;
      acc = (mq.size() > 0) && tx_ready;
      fr  = (mq.size() == 0) || (acc && mq.size() == 1);
      if (acc) void'(mq.pop_front());
      if (fr) begin
        if (m_pe)      begin mq.push_back({4'h1, m_ve[11:8]}); mq.push_back(m_ve[7:0]); m_pe = 0; end
        else if (m_pa) begin mq.push_back(8'h20); mq.push_back(m_va); m_pa = 0; end
        else if (m_pb) begin mq.push_back(8'h30); mq.push_back(m_vb); m_pb = 0; end
        else if (m_pr) begin mq.push_back({4'h8, m_ra}); mq.push_back(m_rd); m_pr = 0; end
      end
      if (upd_eoc) begin m_pe = 1; m_ve = eoc_val; end
      if (upd_a)   begin m_pa = 1; m_va = a_val; end
      if (upd_b)   begin m_pb = 1; m_vb = b_val; end
      if (rd_cmd)  begin m_pr = 1; m_ra = rd_addr; m_rd = rd_data; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R10 cycle model valid", int'(tx_valid), int'(mq.size() > 0));
      if (mq.size() > 0) chk("R10 cycle model byte", int'(tx_byte), int'(mq[0]));
      if (tx_valid && tx_ready) got.push_back(tx_byte);
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
      {upd_eoc, upd_a, upd_b, rd_cmd} = '0;
    end
  endtask

  task automatic drain();
    tx_ready = 1;
    step(12);
  endtask

  task automatic check_log(input string req);
    chk({req, " byte count"}, got.size(), expq.size());
    for (int i = 0; i < expq.size(); i++)
      chk({req, " byte"}, (i < got.size()) ? int'(got[i]) : -1, int'(expq[i]));
    got.delete();
    expq.delete();
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    step(3);
    chk("R1 reset valid", int'(tx_valid), 0);
    rst_n = 1;
    step(3);
    chk("R1 idle valid", int'(tx_valid), 0);
    got.delete();

    // R2 embedded-operations packing
    tx_ready = 1;
    upd_eoc = 1; eoc_val = 12'hA5C; step();
    drain();
    expq = '{8'h1A, 8'h5C}; check_log("R2");

    // R3 byte register indications
    upd_a = 1; a_val = 8'h3C; step();
    upd_b = 1; b_val = 8'hC3; step();
    drain();
    expq = '{8'h20, 8'h3C, 8'h30, 8'hC3}; check_log("R3");

    // R4 / R8 priority order, each reported once
    tx_ready = 0;
    upd_eoc = 1; eoc_val = 12'h123; upd_a = 1; a_val = 8'h11; upd_b = 1; b_val = 8'h22; step();
    step(4);
    drain();
    expq = '{8'h11, 8'h23, 8'h20, 8'h11, 8'h30, 8'h22}; check_log("R4 R8");

    // R6 same-cycle update and read
    rd_cmd = 1; rd_addr = 4'h5; rd_data = 8'h77; upd_a = 1; a_val = 8'h44; step();
    drain();
    expq = '{8'h20, 8'h44, 8'h85, 8'h77}; check_log("R6");

    // R5 read response alone
    rd_cmd = 1; rd_addr = 4'h2; rd_data = 8'h9A; step();
    drain();
    expq = '{8'h82, 8'h9A}; check_log("R5");

    // R7 repeated update while pending
    tx_ready = 0;
    upd_b = 1; b_val = 8'h01; step();
    upd_a = 1; a_val = 8'h10; step();
    upd_a = 1; a_val = 8'h20; step();
    step(2);
    drain();
    expq = '{8'h30, 8'h01, 8'h20, 8'h20}; check_log("R7");

    // R9 update in the grant cycle
    tx_ready = 1;
    upd_a = 1; a_val = 8'h55; step();
    upd_a = 1; a_val = 8'h66; step();
    drain();
    expq = '{8'h20, 8'h55, 8'h20, 8'h66}; check_log("R9");

    // R11 newer read replaces older
    tx_ready = 0;
    upd_b = 1; b_val = 8'h0F; step();
    rd_cmd = 1; rd_addr = 4'h3; rd_data = 8'h11; step();
    rd_cmd = 1; rd_addr = 4'h4; rd_data = 8'h22; step();
    step(2);
    drain();
    expq = '{8'h30, 8'h0F, 8'h84, 8'h22}; check_log("R11");

    // R10 stall holds the byte, second byte follows at once
    tx_ready = 0;
    upd_a = 1; a_val = 8'h99; step();
    step(3);
    chk("R10 stalled valid", int'(tx_valid), 1);
    chk("R10 stalled byte", int'(tx_byte), 8'h20);
    step(2);
    chk("R10 still held", int'(tx_byte), 8'h20);
    tx_ready = 1; step();
    tx_ready = 0;
    chk("R10 second byte next", int'(tx_byte), 8'h99);
    chk("R10 second byte valid", int'(tx_valid), 1);
    step(3);
    drain();
    chk("R10 idle after", int'(tx_valid), 0);
    expq = '{8'h20, 8'h99}; check_log("R10");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule